// File: doc/BRIEF.md
# IQ Sample Format Normalizer

This block turns one raw sample pair, as read from the capture lines, into a pair of signed 16-bit I and Q words ready for the rest of the datapath. The raw fields can arrive with inverted logic levels, with their lines in either bit order, carrying a word of 4 to 16 bits anchored at either end of the lines, and coded as two's complement or offset binary. The block undoes all of this. It can then negate either channel and exchange the two channels.

Each channel goes through a fixed chain of stages. First the line levels are inverted if selected. Then the bit order is reversed if selected. The word is then cut out by size and anchoring. Offset binary is converted to two's complement, the result is sign-extended, the channel is negated if selected, and last the channels are swapped if selected. Negating the most negative value saturates to the most positive value. All settings are static inputs that are sampled together with each valid sample. The result appears one clock later.

Top module: `iq_word_normalizer`

## Requirements
- R1: While reset is asserted, and after it is released until the first valid sample, out_valid is 0 and out_i and out_q are 0.
- R2: out_valid equals in_valid delayed by one clock. out_i and out_q are updated only by a sample taken with in_valid high, and they keep their value in every cycle that follows a cycle with in_valid low.
- R3: With cfg_invert = 1, every raw line of both channels is inverted before any other stage.
- R4: With cfg_msb_first = 0, line k carries weight position k, so line 0 is the LSB side. With cfg_msb_first = 1, the lines are reversed: line 0 is taken as position 15, and so on.
- R5: The word size n is cfg_size clamped to the range 4..16: a value below 4 acts as 4, and a value above 16 acts as 16. Lines outside the word have no effect on the result.
- R6: With cfg_lsb_align = 0, the word occupies positions 15 down to 16-n and its LSB moves with n. With cfg_lsb_align = 1, the word occupies positions n-1 down to 0 and its MSB moves with n.
- R7: With cfg_offset_bin = 0, the n-bit word is two's complement. With cfg_offset_bin = 1, its value is the code minus 2^(n-1). The output is that value as a sign-extended 16-bit two's complement word.
- R8: cfg_neg_i negates the I value and cfg_neg_q negates the Q value. Each acts only on its own channel and is applied after the format conversion.
- R9: Negating -2^(n-1) gives 2^(n-1)-1. It never wraps, so a negated channel never yields -2^15.
- R10: With cfg_swap = 1, out_i carries the fully processed Q channel and out_q carries the fully processed I channel, each with its own negation applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Raw sample strobe |
| in_i | input | 16 | Raw I lines |
| in_q | input | 16 | Raw Q lines |
| cfg_size | input | 5 | Word size in bits, clamped to 4..16 |
| cfg_lsb_align | input | 1 | 1: word anchored at the LSB end, 0: at the MSB end |
| cfg_msb_first | input | 1 | 1: line 0 carries the MSB |
| cfg_invert | input | 1 | 1: raw line levels are inverted |
| cfg_offset_bin | input | 1 | 1: offset binary, 0: two's complement |
| cfg_neg_i | input | 1 | Negate the I channel |
| cfg_neg_q | input | 1 | Negate the Q channel |
| cfg_swap | input | 1 | Exchange the I and Q outputs |
| out_valid | output | 1 | Normalized sample strobe |
| out_i | output | 16 | Normalized signed I |
| out_q | output | 16 | Normalized signed Q |

## Verification
Directed samples set one control at a time. Asymmetric line patterns separate inversion from reversal. Words with ones on lines outside the word show whether those lines leak in. Codes at the midpoint and at both ends of the offset-binary range show whether the conversion and the sign extension are right. The most negative value at sizes 4 and 16 separates saturation from wrap-around, and a sample with swap and one-sided negation shows whether negation is applied before or after the exchange. A long run of random samples and settings, mixed with idle cycles, is then compared cycle by cycle against a behavioural integer model, which catches stage-order mistakes and holding errors that the directed cases miss.

// File: rtl/iq_word_normalizer.sv
module iq_word_normalizer #(
  parameter int W = 16,
  parameter int MINW = 4,
  localparam int SW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [W-1:0]  in_i,
  input  logic [W-1:0]  in_q,
  input  logic [SW-1:0] cfg_size,
  input  logic          cfg_lsb_align,
  input  logic          cfg_msb_first,
  input  logic          cfg_invert,
  input  logic          cfg_offset_bin,
  input  logic          cfg_neg_i,
  input  logic          cfg_neg_q,
  input  logic          cfg_swap,
  output logic          out_valid,
  output logic [W-1:0]  out_i,
  output logic [W-1:0]  out_q
);

  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  logic [SW-1:0] n;
  logic [W-1:0]  mask, half, top;
  logic [W-1:0]  pi, pq;

  // R5: clamp the word size
  assign n = (cfg_size < SW'(MINW)) ? SW'(MINW) :
             (cfg_size > SW'(W))    ? SW'(W)    : cfg_size;
  assign mask = {W{1'b1}} >> (SW'(W) - n);
  assign half = mask >> 1;
  assign top  = mask & ~half;

  function automatic logic [W-1:0] shape(
    input logic [W-1:0]  raw,
    input logic          neg,
    input logic          inv,
    input logic          msbf,
    input logic          lsba,
    input logic          ofs,
    input logic [SW-1:0] sz,
    input logic [W-1:0]  m,
    input logic [W-1:0]  h,
    input logic [W-1:0]  t
  );
    logic [W-1:0] x, y, w, s;
    x = raw ^ {W{inv}};
    for (int k = 0; k < W; k++) y[k] = msbf ? x[W-1-k] : x[k];
    w = lsba ? (y & m) : (y >> (SW'(W) - sz));
    if (ofs) w = w ^ t;
    s = ((w & t) != '0) ? (w | ~m) : w;
    if (neg) s = (s == ~h) ? h : (~s + 1'b1);
    return s;
  endfunction

  assign pi = shape(in_i, cfg_neg_i, cfg_invert, cfg_msb_first, cfg_lsb_align,
                    cfg_offset_bin, n, mask, half, top);
  assign pq = shape(in_q, cfg_neg_q, cfg_invert, cfg_msb_first, cfg_lsb_align,
                    cfg_offset_bin, n, mask, half, top);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_i <= cfg_swap ? pq : pi;
        out_q <= cfg_swap ? pi : pq;
      end
    end
  end

  // R2
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(out_i) && $stable(out_q));

  // R9
  sat_i_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && ((cfg_neg_i && !cfg_swap) || (cfg_neg_q && cfg_swap)) |=> out_i != MOST_NEG);

  // R9
  sat_q_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && ((cfg_neg_q && !cfg_swap) || (cfg_neg_i && cfg_swap)) |=> out_q != MOST_NEG);

endmodule

// File: tb/tb_iq_word_normalizer.sv
`timescale 1ns/1ps
module tb_iq_word_normalizer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_i = '0, in_q = '0;
  logic [4:0]  cfg_size = 5'd16;
  logic        cfg_lsb_align = 0, cfg_msb_first = 0, cfg_invert = 0, cfg_offset_bin = 0;
  logic        cfg_neg_i = 0, cfg_neg_q = 0, cfg_swap = 0;
  logic        out_valid;
  logic [15:0] out_i, out_q;

  int errors = 0;
  int checks = 0;
  logic        exp_v = 1'b0;
  logic [15:0] exp_i = '0, exp_q = '0;

  always #2 clk = ~clk;

  iq_word_normalizer dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .cfg_size(cfg_size), .cfg_lsb_align(cfg_lsb_align), .cfg_msb_first(cfg_msb_first),
    .cfg_invert(cfg_invert), .cfg_offset_bin(cfg_offset_bin), .cfg_neg_i(cfg_neg_i),
    .cfg_neg_q(cfg_neg_q), .cfg_swap(cfg_swap), .out_valid(out_valid),
    .out_i(out_i), .out_q(out_q)
  );

  function automatic logic [15:0] ref_word(logic [15:0] raw, int sz, logic inv,
      logic msbf, logic lsba, logic ofs, logic neg);
    logic [15:0] x, y;
    int n, u, v;
    n = sz < 4 ? 4 : (sz > 16 ? 16 : sz);
    x = inv ? ~raw : raw;
    for (int k = 0; k < 16; k++) y[k] = msbf ? x[15-k] : x[k];
    if (lsba) u = int'({16'd0, y}) % (1 << n);
    else      u = int'({16'd0, y}) / (1 << (16 - n));
    if (ofs) v = u - (1 << (n - 1));
    else     v = (u >= (1 << (n - 1))) ? u - (1 << n) : u;
    if (neg) v = (v == -(1 << (n - 1))) ? (1 << (n - 1)) - 1 : -v;
    return v[15:0];
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic apply(logic v, logic [15:0] i, logic [15:0] q, string tag);
    logic [15:0] ri, rq;
    in_valid = v; in_i = i; in_q = q;
    ri = ref_word(i, int'(cfg_size), cfg_invert, cfg_msb_first, cfg_lsb_align, cfg_offset_bin, cfg_neg_i);
    rq = ref_word(q, int'(cfg_size), cfg_invert, cfg_msb_first, cfg_lsb_align, cfg_offset_bin, cfg_neg_q);
    exp_v = v;
    if (v) begin
      exp_i = cfg_swap ? rq : ri;
      exp_q = cfg_swap ? ri : rq;
    end
    @(negedge clk);
    check(tag, {15'd0, out_valid}, {15'd0, exp_v}, "out_valid");
    check(tag, out_i, exp_i, "out_i");
    check(tag, out_q, exp_q, "out_q");
  endtask

  task automatic cfg(int sz, logic lsba, logic msbf, logic inv, logic ofs,
      logic ni, logic nq, logic sw);
    cfg_size = 5'(sz); cfg_lsb_align = lsba; cfg_msb_first = msbf; cfg_invert = inv;
    cfg_offset_bin = ofs; cfg_neg_i = ni; cfg_neg_q = nq; cfg_swap = sw;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {15'd0, out_valid}, 16'd0, "out_valid in reset");
    check("R1", out_i, 16'd0, "out_i in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {15'd0, out_valid}, 16'd0, "out_valid after reset");
    check("R1", out_q, 16'd0, "out_q after reset");

    cfg(16, 0, 0, 0, 0, 0, 0, 0);
    apply(1, 16'h1234, 16'hFEDC, "R2");
    apply(0, 16'h5555, 16'hAAAA, "R2 hold");
    apply(0, 16'h0F0F, 16'hF0F0, "R2 hold");
    cfg(16, 0, 0, 1, 0, 0, 0, 0);
    apply(1, 16'h1234, 16'h00FF, "R3");
    cfg(16, 0, 1, 0, 0, 0, 0, 0);
    apply(1, 16'h0001, 16'h8003, "R4");
    cfg(16, 0, 1, 1, 0, 0, 0, 0);
    apply(1, 16'h000E, 16'h7000, "R3 R4");
    cfg(4, 1, 0, 0, 0, 0, 0, 0);
    apply(1, 16'hFFF3, 16'h0AA9, "R5");
    cfg(0, 1, 0, 0, 0, 0, 0, 0);
    apply(1, 16'hFFFA, 16'h0007, "R5 clamp low");
    cfg(20, 0, 0, 0, 0, 0, 0, 0);
    apply(1, 16'hC001, 16'h3FFF, "R5 clamp high");
    cfg(8, 0, 0, 0, 0, 0, 0, 0);
    apply(1, 16'hA5FF, 16'h7F00, "R6 msb");
    cfg(8, 1, 0, 0, 0, 0, 0, 0);
    apply(1, 16'hFFA5, 16'h007F, "R6 lsb");
    cfg(12, 1, 0, 0, 1, 0, 0, 0);
    apply(1, 16'h0800, 16'h0000, "R7");
    apply(1, 16'h0FFF, 16'h07FF, "R7");
    cfg(16, 0, 0, 0, 0, 1, 0, 0);
    apply(1, 16'h0005, 16'h0005, "R8");
    cfg(16, 0, 0, 0, 0, 0, 1, 0);
    apply(1, 16'hFFFB, 16'hFFFB, "R8");
    cfg(16, 0, 0, 0, 0, 1, 1, 0);
    apply(1, 16'h8000, 16'h8001, "R9");
    cfg(4, 1, 0, 0, 0, 1, 1, 0);
    apply(1, 16'h0008, 16'h0007, "R9");
    cfg(6, 0, 0, 0, 1, 1, 0, 0);
    apply(1, 16'h0000, 16'hFC00, "R9 offset");
    cfg(16, 0, 0, 0, 0, 1, 0, 1);
    apply(1, 16'h0003, 16'h0100, "R10");
    cfg(10, 1, 1, 1, 1, 0, 1, 1);
    apply(1, 16'h1234, 16'h8765, "R10");

    for (int t = 0; t < 4000; t++) begin
      cfg(int'($urandom_range(0, 31)), 1'($urandom), 1'($urandom), 1'($urandom),
          1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      apply(($urandom_range(0, 3) != 0), 16'($urandom), 16'($urandom), "R2-mix R7 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule